// File: doc/BRIEF.md
# SDRAM Open-Page Command Sequencer

This block drives the command side of a four-bank, 16-bit synchronous DRAM for one page session. A request names a bank, a row, a short list of column operations (each a read or a write with its own column and a requested spacing to the next one) and a lead time for closing the page. The sequencer activates the row, issues the column commands back to back inside that page, and closes the bank with a precharge. Every column command starts a four-word burst. A later command may cut an earlier burst short, and the precharge may also cut a write burst short.

The command pins are registered. A write that follows a read is preceded by three cycles of DQM so that the memory has released DQ before the controller drives it. A write cut short by precharge gets DQM on the precharge cycle. The write-data source supplies `wdata` combinationally in every cycle where `dq_oe` is high, and it uses `wr_op`/`wr_beat` to pick the word. `rd_valid` marks the cycles where DQ carries an unmasked read word from this session. The CAS latency of 2 or 3 is chosen by `cas3`. Timing limits are parameters: `T_RCD`, `T_CDL` and `T_RDL`.

Top module: `sdram_page_seq`

## Requirements
- R1: While reset is held, the block drives CKE low, a NOP command, DQM low, dq_oe low and done low. From the first cycle after reset it drives CKE high and req_ready high.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: activate 0011, read 0101, write 0100, precharge 0010, NOP 0111. Every cycle without an event carries NOP.
- R3: A request is taken only on a clock edge where req_ready is high. The activate follows in the next cycle with the requested bank on ba and the row on addr. Request inputs are latched at that edge, and changing them or holding req_valid during the session has no effect.
- R4: The first column command comes exactly T_RCD cycles after the activate.
- R5: The spacing from column op i to op i+1 is the largest of: the requested gap for op i, T_CDL, and 4 when a write follows a read.
- R6: A column command carries the latched bank on ba and its column on addr[7:0]. addr[10] is low on it, so there is no auto-precharge.
- R7: DQM is high in exactly the three cycles before each write that follows a read.
- R8: dq_oe is high exactly in the cycles of a write burst: from the write command up to four cycles, ending early at the next column command or at the precharge. In those cycles dq_out equals wdata, wr_op is the op index and wr_beat is the word index 0..3. Otherwise dq_out is zero.
- R9: rd_valid is high in cycle c exactly when cycle c-CL carried a read burst word (same rule as R8) and DQM was low in cycle c-2. CL is 3 when cas3 is high, else 2.
- R10: The precharge comes after the last column op by the largest of: the requested close lead, T_RDL if that op is a write, 4 if it is a read, and 1. It carries the bank on ba and addr[10] low.
- R11: When a precharge cuts a write burst short (close spacing under 4), DQM is high on the precharge cycle. dq_oe is low from the precharge cycle on.
- R12: done is a one-cycle pulse in the cycle after the precharge. req_ready is low from the activate through that cycle and high again in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas3 | input | 1 | CAS latency select: 1 = 3 cycles, 0 = 2 cycles |
| req_valid | input | 1 | Request present |
| req_bank | input | 2 | Bank to open |
| req_row | input | 12 | Row to open |
| req_last | input | 2 | Index of the last column op (op count minus 1) |
| req_wr | input | 4 | Per op: 1 = write, 0 = read |
| req_col | input | 32 | Per op column, op i at bits [8i+7:8i] |
| req_gap | input | 12 | Per op requested spacing to the next op, op i at bits [3i+2:3i] |
| req_pgap | input | 3 | Requested spacing from the last op to precharge |
| wdata | input | 16 | Write word for the current write beat |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | Session finished pulse |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| addr | output | 12 | Address; bit 10 is the auto-precharge flag |
| dqm | output | 1 | Data mask |
| dq_oe | output | 1 | Controller drives DQ |
| dq_out | output | 16 | Data driven on DQ |
| wr_op | output | 2 | Op index of the current write beat |
| wr_beat | output | 2 | Word index of the current write beat |
| rd_valid | output | 1 | DQ holds a valid read word this cycle |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the pre-write DQM window and the tail of a read burst that is still returning data: a read followed by a write at the minimum spacing of 4, at both latencies, makes the mask fall on read words that would otherwise be valid. The bench derives rd_valid arithmetically from the masked cycle two cycles earlier. The second pair is the precharge and a live write burst: close lead times of 0 to 7 after a final write put the precharge inside the burst or after it, and the bench checks DQM and dq_oe in that exact cycle.

// File: rtl/sdram_page_seq.sv
module sdram_page_seq #(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int BANK_W  = 2,
  parameter int DATA_W  = 16,
  parameter int MAX_OPS = 4,
  parameter int GAP_W   = 3,
  parameter int T_RCD   = 2,
  parameter int T_CDL   = 1,
  parameter int T_RDL   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cas3,
  input  logic                     req_valid,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [$clog2(MAX_OPS)-1:0] req_last,
  input  logic [MAX_OPS-1:0]       req_wr,
  input  logic [MAX_OPS*COL_W-1:0] req_col,
  input  logic [MAX_OPS*GAP_W-1:0] req_gap,
  input  logic [GAP_W-1:0]         req_pgap,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     req_ready,
  output logic                     done,
  output logic                     cke,
  output logic                     cs_n,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic [BANK_W-1:0]        ba,
  output logic [ROW_W-1:0]         addr,
  output logic                     dqm,
  output logic                     dq_oe,
  output logic [DATA_W-1:0]        dq_out,
  output logic [$clog2(MAX_OPS)-1:0] wr_op,
  output logic [1:0]               wr_beat
  ,output logic                    rd_valid
);
  localparam int OPI_W = $clog2(MAX_OPS);
  localparam int CNT_W = 6;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_NOP = 4'b0111;

  typedef enum logic [2:0] {S_IDLE, S_ACTW, S_COLW, S_PRES, S_DONE} st_t;

  st_t st;
  logic [CNT_W-1:0]         cnt, gap_after;
  logic [OPI_W-1:0]         opi, iss, iss_n, bop;
  logic [2:0]               bleft;
  logic                     bwr;
  logic [BANK_W-1:0]        l_bank;
  logic [OPI_W-1:0]         l_last;
  logic [MAX_OPS-1:0]       l_wr;
  logic [MAX_OPS*COL_W-1:0] l_col;
  logic [MAX_OPS*GAP_W-1:0] l_gap;
  logic [GAP_W-1:0]         l_pgap;
  logic [3:0]               cmd_q;
  logic                     cke_q, dqm_q, done_q, pre_win;
  logic [2:0]               slot_d;
  logic [1:0]               dqm_h;
  int                       g, p;

  assign iss   = (st == S_ACTW) ? opi : OPI_W'(opi + 1'b1);
  assign iss_n = OPI_W'(iss + 1'b1);

  always_comb begin
    g = int'(l_gap[iss*GAP_W +: GAP_W]);
    if (g < T_CDL) g = T_CDL;
    if (l_wr[iss_n] && !l_wr[iss] && g < 4) g = 4;
    p = int'(l_pgap);
    if (l_wr[iss]) begin
      if (p < T_RDL) p = T_RDL;
    end else if (p < 4) p = 4;
    if (p < 1) p = 1;
    gap_after = (iss == l_last) ? CNT_W'(p) : CNT_W'(g);
  end

  assign pre_win = (st == S_COLW) && (opi != l_last) && l_wr[iss] && !l_wr[opi] &&
                   (cnt >= CNT_W'(2)) && (cnt <= CNT_W'(4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      opi    <= '0;
      bop    <= '0;
      bleft  <= '0;
      bwr    <= 1'b0;
      l_bank <= '0;
      l_last <= '0;
      l_wr   <= '0;
      l_col  <= '0;
      l_gap  <= '0;
      l_pgap <= '0;
      cmd_q  <= C_NOP;
      ba     <= '0;
      addr   <= '0;
      cke_q  <= 1'b0;
      dqm_q  <= 1'b0;
      done_q <= 1'b0;
      slot_d <= '0;
      dqm_h  <= '0;
    end else begin
      cke_q  <= 1'b1;
      cmd_q  <= C_NOP;
      dqm_q  <= 1'b0;
      done_q <= 1'b0;
      slot_d <= {slot_d[1:0], (bleft != 3'd0) && !bwr};
      dqm_h  <= {dqm_h[0], dqm_q};
      if (bleft != 3'd0) bleft <= bleft - 3'd1;
      case (st)
        S_IDLE: if (req_valid) begin
          l_bank <= req_bank;
          l_last <= req_last;
          l_wr   <= req_wr;
          l_col  <= req_col;
          l_gap  <= req_gap;
          l_pgap <= req_pgap;
          cmd_q  <= C_ACT;
          ba     <= req_bank;
          addr   <= req_row;
          cnt    <= CNT_W'(T_RCD);
          opi    <= '0;
          st     <= S_ACTW;
        end
        S_ACTW, S_COLW: begin
          if (cnt == CNT_W'(1)) begin
            ba <= l_bank;
            if (st == S_COLW && opi == l_last) begin
              cmd_q <= C_PRE;
              addr  <= '0;
              bleft <= '0;
              dqm_q <= bwr && (bleft > 3'd1);
              st    <= S_PRES;
            end else begin
              cmd_q <= l_wr[iss] ? C_WR : C_RD;
              addr  <= ROW_W'(l_col[iss*COL_W +: COL_W]);
              cnt   <= gap_after;
              opi   <= iss;
              bop   <= iss;
              bleft <= 3'd4;
              bwr   <= l_wr[iss];
              st    <= S_COLW;
            end
          end else begin
            cnt   <= cnt - CNT_W'(1);
            dqm_q <= pre_win;
          end
        end
        S_PRES: begin
          done_q <= 1'b1;
          st     <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign cke       = cke_q;
  assign dqm       = dqm_q;
  assign done      = done_q;
  assign req_ready = (st == S_IDLE);
  assign dq_oe     = (bleft != 3'd0) && bwr;
  assign dq_out    = dq_oe ? wdata : '0;
  assign wr_op     = bop;
  assign wr_beat   = 2'(3'd4 - bleft);
  assign rd_valid  = (cas3 ? slot_d[2] : slot_d[1]) && !dqm_h[1];
endmodule

module sdram_page_seq_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic             dqm,
  input logic             dq_oe,
  input logic             done,
  input logic             req_ready
);
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd inside {4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0111});

  assert_col_no_autopre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> !addr[10]);

  assert_pre_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> !dq_oe);

  assert_done_after_pre_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd) == 4'b0010);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == 4'b0111 && !dq_oe));

  assert_drive_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !dqm);
endmodule

bind sdram_page_seq sdram_page_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .dqm(dqm), .dq_oe(dq_oe), .done(done), .req_ready(req_ready)
);

// File: tb/sdram_page_seq_test.sv
`timescale 1ns/1ps
module sdram_page_seq_test;
  localparam int RCD = 2, CDL = 1, RDL = 2;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cas3 = 1'b0, req_valid = 1'b0;
  logic [1:0]  req_bank = '0, req_last = '0;
  logic [11:0] req_row = '0;
  logic [3:0]  req_wr = '0;
  logic [31:0] req_col = '0;
  logic [11:0] req_gap = '0;
  logic [2:0]  req_pgap = '0;
  logic [15:0] wdata = '0;
  logic        req_ready, done, cke, cs_n, ras_n, cas_n, we_n, dqm, dq_oe, rd_valid;
  logic [1:0]  ba, wr_op, wr_beat;
  logic [11:0] addr;
  logic [15:0] dq_out;

  sdram_page_seq #(.T_RCD(RCD), .T_CDL(CDL), .T_RDL(RDL)) uut (
    .clk(clk), .rst_n(rst_n), .cas3(cas3), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_last(req_last), .req_wr(req_wr), .req_col(req_col),
    .req_gap(req_gap), .req_pgap(req_pgap), .wdata(wdata), .req_ready(req_ready),
    .done(done), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dqm(dqm), .dq_oe(dq_oe), .dq_out(dq_out), .wr_op(wr_op),
    .wr_beat(wr_beat), .rd_valid(rd_valid));

  int tests = 0, fails = 0;
  int q_last, q_pgap, q_row, q_bank, q_gap[4], q_col[4], t_[4], tp_, gp_, seq = 0;
  bit q_wr[4], q_cas3, q_hold;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", rq, what, act, exp, $time);
    end
  endtask

  function automatic int owner(input int c);
    int o = -1;
    for (int i = 0; i <= q_last; i++) begin
      int e = t_[i] + 4;
      int nx = (i < q_last) ? t_[i+1] : tp_;
      if (nx < e) e = nx;
      if (c >= t_[i] && c < e) o = i;
    end
    return o;
  endfunction

  function automatic bit dqm_e(input int c);
    bit m = (c == tp_) && q_wr[q_last] && (gp_ < 4);
    for (int i = 0; i < q_last; i++)
      if (q_wr[i+1] && !q_wr[i] && c >= t_[i+1] - 3 && c < t_[i+1]) m = 1'b1;
    return m;
  endfunction

  task automatic run();
    int cl = q_cas3 ? 3 : 2;
    t_[0] = RCD;
    for (int i = 0; i < q_last; i++) begin
      int g = q_gap[i];
      if (g < CDL) g = CDL;
      if (q_wr[i+1] && !q_wr[i] && g < 4) g = 4;
      t_[i+1] = t_[i] + g;
    end
    gp_ = q_pgap;
    if (q_wr[q_last] && gp_ < RDL) gp_ = RDL;
    if (!q_wr[q_last] && gp_ < 4) gp_ = 4;
    if (gp_ < 1) gp_ = 1;
    tp_ = t_[q_last] + gp_;
    cas3 = q_cas3; req_bank = 2'(q_bank); req_row = 12'(q_row); req_last = 2'(q_last);
    req_pgap = 3'(q_pgap);
    for (int i = 0; i < 4; i++) begin
      req_wr[i] = q_wr[i];
      req_col[i*8 +: 8] = 8'(q_col[i]);
      req_gap[i*3 +: 3] = 3'(q_gap[i]);
    end
    req_valid = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= tp_ + 2; c++) begin
      logic [3:0] ec;
      int o, oc;
      @(negedge clk);
      seq++;
      wdata = 16'(16'h3C00 ^ (seq * 37));
      #1;
      ec = C_NOP;
      if (c == 0) ec = C_ACT;
      if (c == tp_) ec = C_PRE;
      for (int i = 0; i <= q_last; i++) if (c == t_[i]) ec = q_wr[i] ? C_WR : C_RD;
      chk({cs_n, ras_n, cas_n, we_n} == ec,
          c == 0 ? "R3" : c == t_[0] ? "R4" : c == tp_ ? "R10" : (ec != C_NOP) ? "R5" : "R2",
          "command", {cs_n, ras_n, cas_n, we_n}, ec);
      if (c == 0) begin
        chk(ba == 2'(q_bank), "R3", "activate bank", ba, q_bank);
        chk(addr == 12'(q_row), "R3", "activate row", addr, q_row);
      end
      for (int i = 0; i <= q_last; i++) if (c == t_[i]) begin
        chk(ba == 2'(q_bank), "R6", "column bank", ba, q_bank);
        chk(addr[7:0] == 8'(q_col[i]), "R6", "column", addr[7:0], q_col[i]);
        chk(addr[10] == 1'b0, "R6", "A10 on column", addr[10], 0);
      end
      if (c == tp_) begin
        chk(ba == 2'(q_bank), "R10", "precharge bank", ba, q_bank);
        chk(addr[10] == 1'b0, "R10", "A10 on precharge", addr[10], 0);
      end
      chk(dqm == dqm_e(c), c == tp_ ? "R11" : "R7", "dqm", dqm, dqm_e(c));
      o = owner(c);
      chk(dq_oe == (o >= 0 && q_wr[o]), c == tp_ ? "R11" : "R8", "dq_oe", dq_oe, o >= 0 && q_wr[o]);
      if (o >= 0 && q_wr[o]) begin
        chk(dq_out == wdata, "R8", "dq_out", dq_out, wdata);
        chk(wr_op == 2'(o), "R8", "wr_op", wr_op, o);
        chk(wr_beat == 2'(c - t_[o]), "R8", "wr_beat", wr_beat, c - t_[o]);
      end else chk(dq_out == 16'h0, "R8", "dq_out idle", dq_out, 0);
      oc = (c - cl >= 0) ? owner(c - cl) : -1;
      begin
        bit er = (oc >= 0) && !q_wr[oc] && !((c - 2 >= 0) && dqm_e(c - 2));
        chk(rd_valid == er, "R9", "rd_valid", rd_valid, er);
      end
      chk(done == (c == tp_ + 1), "R12", "done", done, c == tp_ + 1);
      chk(req_ready == (c == tp_ + 2), c == tp_ + 2 ? "R12" : "R3", "req_ready", req_ready, c == tp_ + 2);
      if (q_hold && c < tp_ + 2) begin
        req_row = ~req_row; req_bank = ~req_bank; req_col = ~req_col; req_wr = ~req_wr;
      end else req_valid = 1'b0;
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", "cmd in reset", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk(dqm == 1'b0, "R1", "dqm in reset", dqm, 0);
    chk(dq_oe == 1'b0, "R1", "dq_oe in reset", dq_oe, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke == 1'b1, "R1", "cke after reset", cke, 1);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    for (int c3 = 0; c3 < 2; c3++)
      for (int w = 0; w < 4; w++)
        for (int g = 0; g < 8; g++)
          for (int p = 0; p < 8; p++) begin
            q_cas3 = c3[0]; q_last = 1; q_pgap = p; q_hold = (p == 3);
            q_wr[0] = w[0]; q_wr[1] = w[1]; q_wr[2] = 0; q_wr[3] = 0;
            q_gap[0] = g; q_gap[1] = 0; q_gap[2] = 0; q_gap[3] = 0;
            for (int i = 0; i < 4; i++) q_col[i] = (g * 31 + p * 7 + i * 59 + w) & 8'hFF;
            q_bank = (g + p) & 3; q_row = (g * 97 + p * 13 + w * 401) & 12'hFFF;
            run();
          end

    for (int c3 = 0; c3 < 2; c3++)
      for (int w = 0; w < 16; w++)
        for (int v = 0; v < 3; v++)
          for (int pi = 0; pi < 2; pi++) begin
            q_cas3 = c3[0]; q_last = 3; q_pgap = pi ? 6 : 0; q_hold = (v == 1);
            for (int i = 0; i < 4; i++) begin
              q_wr[i] = w[i];
              q_gap[i] = (v == 0) ? 0 : (v == 1) ? i + 1 : 7 - ((i * 3) % 4);
              q_col[i] = (w * 17 + i * 83 + v) & 8'hFF;
            end
            q_bank = (w + v) & 3; q_row = (w * 251 + v * 7 + pi) & 12'hFFF;
            run();
          end

    for (int c3 = 0; c3 < 2; c3++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 8; p++) begin
          q_cas3 = c3[0]; q_last = 0; q_pgap = p; q_hold = 0;
          q_wr[0] = w[0]; q_wr[1] = 0; q_wr[2] = 0; q_wr[3] = 0;
          for (int i = 0; i < 4; i++) begin q_gap[i] = 0; q_col[i] = (p * 41 + i) & 8'hFF; end
          q_bank = p & 3; q_row = 12'hFFF - p;
          run();
        end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule